// File: doc/BRIEF.md
# Multispeed Data-Strobe Serial Codec

This block turns parallel words from a link controller into a two-wire data-strobe line code, and turns a received data-strobe pair back into parallel words. Every system clock cycle the link side moves one word of 2, 4 or 8 bits. The width depends on the speed code. The serial bit rate is therefore 2, 4 or 8 times the system clock. The serial side runs on a fast bit clock at 8 times the system clock, and is phase locked to it. At the slower speeds each line bit is held for 4 or 2 fast cycles.

On the transmit side, the word is captured on the system clock and sent MSB first. The data line changes when the new bit differs from the last data level. Otherwise the strobe line toggles, so every bit moves exactly one of the two wires. Data leaves on the B-pair output and strobe on the A-pair output. On the receive side, data comes in on the A pair and strobe on the B pair. A new bit is seen whenever the XOR of the two levels changes. Bits are grouped into words of the width set by the receive speed code. The words cross into the system clock domain through a four-entry asynchronous FIFO.

The receive output is a valid/ready stream. Once `rx_valid` is high, `rx_word` holds steady until `rx_ready` takes it. The link may hold `rx_ready` low for as long as it likes, but a word that arrives while the FIFO is full is lost and flagged. The transmit input has no back-pressure: `tx_ready` stays high out of reset and one word is taken on every system clock cycle in which `tx_valid` is high.

Top module: `ds_codec`

## Requirements
- R1: While reset is asserted and just after it is released, both line outputs are 0, `rx_valid` is 0 and `rx_overflow` is 0.
- R2: Each transmitted bit moves exactly one line. The data line (B-pair output) goes to the bit value when it differs from the previous data level; otherwise the strobe line (A-pair output) toggles.
- R3: Speed code 0 sends `tx_word[1:0]`, code 1 sends `tx_word[3:0]`, and codes 2 and 3 send `tx_word[7:0]`. Bits in an unbroken run of words are spaced 4, 2 or 1 fast clocks apart for these codes, so 2, 4 or 8 bits go out per system cycle.
- R4: The highest bit of the active field is sent first, and the rest follow in descending bit order.
- R5: In a system cycle with `tx_valid` low, no bit is sent and both line outputs keep their levels.
- R6: The receiver takes a bit each time the XOR of the A-pair and B-pair inputs changes, with the bit value equal to the A-pair level. It packs 2, 4 or 8 bits (by `rx_speed`, same codes as R3), first bit at the top of the field, into `rx_word`, with the unused upper bits 0. While `rx_en` is low no word is formed, and the bit count restarts from zero.
- R7: Received words come out in arrival order. While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_word` stays stable.
- R8: The FIFO holds 4 words. A word that arrives while it is full is dropped and the words already held are kept. After a drop, `rx_overflow` goes high and stays high until reset.
- R9: `tx_ready` is high on every system cycle after the first one out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; link-side words move once per cycle |
| bit_clk | input | 1 | Fast clock at 8 times sys_clk, phase locked to it |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tx_valid | input | 1 | Transmit word present this system cycle |
| tx_ready | output | 1 | High whenever a transmit word can be taken |
| tx_word | input | 8 | Transmit word; low 2/4/8 bits used per speed |
| tx_speed | input | 2 | Transmit speed code, captured with the word |
| line_a_out | output | 1 | Encoded strobe toward the A pair |
| line_b_out | output | 1 | Encoded data toward the B pair |
| line_a_in | input | 1 | Received data level from the A pair (bit_clk domain) |
| line_b_in | input | 1 | Received strobe level from the B pair (bit_clk domain) |
| rx_en | input | 1 | Receive framing enable (bit_clk domain); low clears the bit count |
| rx_speed | input | 2 | Receive speed code (bit_clk domain) |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Link accepts the received word |
| rx_word | output | 8 | Received word, right-aligned |
| rx_overflow | output | 1 | Sticky flag: a received word was dropped |

## Verification
Words of all zeros and all ones make the strobe carry every bit. An encoder that changed data on every one bit, or moved both wires, would break the one-line-per-bit rule and decode to a wrong value. Each speed code is looped back with upper bits set above the active field. A wrong width, a wrong order or poor masking would show as spacing errors on the line or as stray bits in `rx_word`. A partial word left in the receiver and then cut off by `rx_en` checks the count restart: a design that kept the count would misalign every later word. Holding `rx_ready` low tests both holding a word steady and overflow. An overflow that evicted old words, or a flag that cleared itself, would deliver the wrong four words.

// File: rtl/ds_codec_pkg.sv
package ds_codec_pkg;
  // widest parallel word; also the fast-to-system clock ratio
  localparam int unsigned WORD_W = 8;

  typedef logic [1:0] spd_t;

  function automatic logic [3:0] bits_per_word(input spd_t spd);
    case (spd)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [2:0] fast_per_bit(input spd_t spd);
    case (spd)
      2'd0:    return 3'd4;
      2'd1:    return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] field_mask(input spd_t spd);
    case (spd)
      2'd0:    return WORD_W'(8'h03);
      2'd1:    return WORD_W'(8'h0F);
      default: return WORD_W'(8'hFF);
    endcase
  endfunction
endpackage

// File: rtl/ds_tx_encoder.sv
module ds_tx_encoder
  import ds_codec_pkg::*;
(
  input  logic              sys_clk,
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_word,
  input  spd_t              tx_speed,
  output logic              line_d,
  output logic              line_s
);
  // system-domain capture
  logic [WORD_W-1:0] hold_word;
  spd_t              hold_spd;
  logic              hold_vld;
  logic              tick_sys;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word <= '0;
      hold_spd  <= '0;
      hold_vld  <= 1'b0;
      tick_sys  <= 1'b0;
    end else begin
      hold_vld <= tx_valid;
      tick_sys <= ~tick_sys;
      if (tx_valid) begin
        hold_word <= tx_word;
        hold_spd  <= tx_speed;
      end
    end
  end

  // fast-domain serializer
  logic              tick_bit;
  logic [WORD_W-1:0] shreg;
  logic [3:0]        left;
  logic [2:0]        wait_cnt;
  spd_t              cur_spd;
  logic              d_q, s_q;
  logic              load;
  logic [WORD_W-1:0] aligned;
  logic              emit;
  logic              bit_val;

  assign load    = tick_sys != tick_bit;
  assign aligned = hold_word << (4'd8 - bits_per_word(hold_spd));

  always_comb begin
    emit    = 1'b0;
    bit_val = shreg[WORD_W-1];
    if (load) begin
      emit    = hold_vld;
      bit_val = aligned[WORD_W-1];
    end else if (left != 4'd0 && wait_cnt == 3'd0) begin
      emit = 1'b1;
    end
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_bit <= 1'b0;
      shreg    <= '0;
      left     <= 4'd0;
      wait_cnt <= 3'd0;
      cur_spd  <= '0;
      d_q      <= 1'b0;
      s_q      <= 1'b0;
    end else begin
      if (load) begin
        tick_bit <= tick_sys;
        cur_spd  <= hold_spd;
        if (hold_vld) begin
          shreg    <= aligned << 1;
          left     <= bits_per_word(hold_spd) - 4'd1;
          wait_cnt <= fast_per_bit(hold_spd) - 3'd1;
        end else begin
          left <= 4'd0;
        end
      end else if (left != 4'd0) begin
        if (wait_cnt == 3'd0) begin
          shreg    <= shreg << 1;
          left     <= left - 4'd1;
          wait_cnt <= fast_per_bit(cur_spd) - 3'd1;
        end else begin
          wait_cnt <= wait_cnt - 3'd1;
        end
      end
      if (emit) begin
        if (bit_val != d_q) d_q <= bit_val;
        else                s_q <= ~s_q;
      end
    end
  end

  assign line_d = d_q;
  assign line_s = s_q;

  AST_ONE_LINE_MOVES: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !((line_d != $past(line_d)) && (line_s != $past(line_s)))); // R2
  AST_WORD_DONE_BEFORE_LOAD: assert property (@(posedge bit_clk) disable iff (!rst_n)
    load |-> left == 4'd0); // R3
endmodule

// File: rtl/ds_rx_decoder.sv
module ds_rx_decoder
  import ds_codec_pkg::*;
(
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              line_d,
  input  logic              line_s,
  input  logic              rx_en,
  input  spd_t              rx_speed,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);
  logic              d_q, s_q, en_q, x_prev;
  spd_t              spd_q;
  logic [WORD_W-1:0] acc;
  logic [3:0]        cnt;
  logic              bit_edge;
  logic              last_bit;
  logic [WORD_W-1:0] acc_next;

  assign bit_edge = (d_q ^ s_q) != x_prev;
  assign last_bit = cnt == (bits_per_word(spd_q) - 4'd1);
  assign acc_next = {acc[WORD_W-2:0], d_q};

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q    <= 1'b0;
      s_q    <= 1'b0;
      en_q   <= 1'b0;
      spd_q  <= '0;
      x_prev <= 1'b0;
      acc    <= '0;
      cnt    <= 4'd0;
    end else begin
      d_q    <= line_d;
      s_q    <= line_s;
      en_q   <= rx_en;
      spd_q  <= rx_speed;
      x_prev <= d_q ^ s_q;
      if (!en_q) begin
        acc <= '0;
        cnt <= 4'd0;
      end else if (bit_edge) begin
        acc <= acc_next;
        cnt <= last_bit ? 4'd0 : cnt + 4'd1;
      end
    end
  end

  assign push      = en_q && bit_edge && last_bit;
  assign push_word = acc_next & field_mask(spd_q);

  AST_RX_RESTART: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !en_q |=> cnt == 4'd0); // R6
  AST_RX_NO_PUSH_IDLE: assert property (@(posedge bit_clk) disable iff (!rst_n)
    push |-> $past(rx_en)); // R6
endmodule

// File: rtl/ds_cdc_fifo.sv
module ds_cdc_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SYNC  = 2
) (
  input  logic          rst_n,
  input  logic          wclk,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rclk,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          ovf
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] wg_pipe [SYNC];
  logic [PW-1:0] rg_pipe [SYNC];
  logic [PW-1:0] wbin_s, rbin_s;
  logic          full, empty, ovf_w;
  logic [SYNC-1:0] ovf_pipe;

  assign wgray  = to_gray(wbin);
  assign rgray  = to_gray(rbin);
  assign rbin_s = from_gray(rg_pipe[SYNC-1]);
  assign wbin_s = from_gray(wg_pipe[SYNC-1]);
  assign full   = (wbin - rbin_s) == PW'(DEPTH);
  assign empty  = rbin == wbin_s;

  // write domain
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      ovf_w <= 1'b0;
      for (int i = 0; i < SYNC; i++) rg_pipe[i] <= '0;
    end else begin
      rg_pipe[0] <= rgray;
      for (int i = 1; i < SYNC; i++) rg_pipe[i] <= rg_pipe[i-1];
      if (wr_en && !full) wbin <= wbin + 1'b1;
      if (wr_en && full)  ovf_w <= 1'b1;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_en && !full) mem[wbin[AW-1:0]] <= wr_data;
  end

  // read domain
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      ovf_pipe <= '0;
      for (int i = 0; i < SYNC; i++) wg_pipe[i] <= '0;
    end else begin
      wg_pipe[0] <= wgray;
      for (int i = 1; i < SYNC; i++) wg_pipe[i] <= wg_pipe[i-1];
      ovf_pipe <= {ovf_pipe[SYNC-2:0], ovf_w};
      if (rd_ready && !empty) rbin <= rbin + 1'b1;
    end
  end

  assign rd_valid = !empty;
  assign rd_data  = mem[rbin[AW-1:0]];
  assign ovf      = ovf_pipe[SYNC-1];

  AST_GRAY_ONE_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R8
  AST_OVF_STICKY: assert property (@(posedge wclk) disable iff (!rst_n)
    ovf_w |=> ovf_w); // R8
  AST_OCC_BOUND: assert property (@(posedge rclk) disable iff (!rst_n)
    (wbin_s - rbin) <= PW'(DEPTH)); // R8
  AST_RD_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R7
endmodule

// File: rtl/ds_codec.sv
module ds_codec
  import ds_codec_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              sys_clk,
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [1:0]        tx_speed,
  output logic              line_a_out,
  output logic              line_b_out,
  input  logic              line_a_in,
  input  logic              line_b_in,
  input  logic              rx_en,
  input  logic [1:0]        rx_speed,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_overflow
);
  logic              ready_q;
  logic              rx_push;
  logic [WORD_W-1:0] rx_push_word;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign tx_ready = ready_q;

  ds_tx_encoder u_tx (
    .sys_clk  (sys_clk),
    .bit_clk  (bit_clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_word  (tx_word),
    .tx_speed (tx_speed),
    .line_d   (line_b_out),
    .line_s   (line_a_out)
  );

  ds_rx_decoder u_rx (
    .bit_clk   (bit_clk),
    .rst_n     (rst_n),
    .line_d    (line_a_in),
    .line_s    (line_b_in),
    .rx_en     (rx_en),
    .rx_speed  (rx_speed),
    .push      (rx_push),
    .push_word (rx_push_word)
  );

  ds_cdc_fifo #(
    .DW    (WORD_W),
    .DEPTH (FIFO_DEPTH),
    .SYNC  (SYNC_STAGES)
  ) u_fifo (
    .rst_n    (rst_n),
    .wclk     (bit_clk),
    .wr_en    (rx_push),
    .wr_data  (rx_push_word),
    .rclk     (sys_clk),
    .rd_valid (rx_valid),
    .rd_ready (rx_ready),
    .rd_data  (rx_word),
    .ovf      (rx_overflow)
  );

  AST_READY_AFTER_RESET: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $past(rst_n) |-> tx_ready); // R9
endmodule

// File: tb/test_ds_codec.sv
module test_ds_codec;
  localparam int FAST_PERIOD  = 2;
  localparam int WATCHDOG_CYC = 120000;

  logic bit_clk = 1'b0;
  logic sys_clk = 1'b0;
  logic [2:0] div = 3'd0;
  logic rst_n = 1'b0;

  logic       tx_valid = 1'b0;
  logic [7:0] tx_word  = 8'd0;
  logic [1:0] tx_speed = 2'd0;
  logic       tx_ready;
  logic       line_a_out, line_b_out;
  logic       rx_en    = 1'b0;
  logic [1:0] rx_speed = 2'd0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_word;
  logic       rx_overflow;

  initial forever #(FAST_PERIOD/2) bit_clk = ~bit_clk;
  always @(posedge bit_clk) begin
    div     <= div + 3'd1;
    sys_clk <= div[2];
  end

  ds_codec i_ds_codec (
    .sys_clk(sys_clk), .bit_clk(bit_clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_word(tx_word), .tx_speed(tx_speed),
    .line_a_out(line_a_out), .line_b_out(line_b_out),
    .line_a_in(line_b_out), .line_b_in(line_a_out),
    .rx_en(rx_en), .rx_speed(rx_speed),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_word(rx_word), .rx_overflow(rx_overflow)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] txw [0:15];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wpb(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
  endfunction
  function automatic int fpb(input logic [1:0] s);
    return (s == 2'd0) ? 4 : (s == 2'd1) ? 2 : 1;
  endfunction
  function automatic logic [7:0] msk(input logic [1:0] s);
    return (s == 2'd0) ? 8'h03 : (s == 2'd1) ? 8'h0F : 8'hFF;
  endfunction

  // line monitor: decodes the transmit pair independently
  logic prev_a = 1'b0, prev_b = 1'b0;
  int   fidx = 0, nobs = 0, both_err = 0, gap_err = 0, last_idx = 0, exp_gap = 1;
  bit   have_last = 1'b0, gap_on = 1'b0, gap_on_q = 1'b0;
  logic obs [0:4095];

  always @(negedge bit_clk) begin
    fidx++;
    if (gap_on && !gap_on_q) have_last = 1'b0;
    gap_on_q = gap_on;
    if (rst_n) begin
      if (line_a_out != prev_a && line_b_out != prev_b) both_err++;
      if (line_a_out != prev_a || line_b_out != prev_b) begin
        if (nobs < 4096) obs[nobs] = line_b_out;
        nobs++;
        if (gap_on && have_last && (fidx - last_idx) != exp_gap) gap_err++;
        last_idx  = fidx;
        have_last = 1'b1;
      end
    end
    prev_a = line_a_out;
    prev_b = line_b_out;
  end

  // receive collector
  logic [7:0] got [0:255];
  int ngot = 0;
  always @(negedge sys_clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (ngot < 256) got[ngot] = rx_word;
      ngot++;
    end
  end

  task automatic sys_cycles(input int n);
    repeat (n) @(posedge sys_clk);
    #1;
  endtask

  task automatic send_words(input logic [1:0] spd, input int n, inout int rdy_bad);
    for (int i = 0; i < n; i++) begin
      tx_valid = 1'b1;
      tx_speed = spd;
      tx_word  = txw[i];
      if (!tx_ready) rdy_bad++;
      sys_cycles(1);
    end
    tx_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(line_a_out == 1'b0, "R1 line_a_out", line_a_out, 0);
    check(line_b_out == 1'b0, "R1 line_b_out", line_b_out, 0);
    check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    check(rx_overflow == 1'b0, "R1 rx_overflow", rx_overflow, 0);
    sys_cycles(2);
    check(tx_ready == 1'b1, "R9 tx_ready after reset", tx_ready, 1);
    check(line_a_out == 1'b0 && line_b_out == 1'b0, "R1 lines after release",
          {line_a_out, line_b_out}, 0);
  endtask

  task automatic t_idle();
    int   ob0;
    logic a0, b0;
    ob0 = nobs; a0 = line_a_out; b0 = line_b_out;
    tx_valid = 1'b0;
    sys_cycles(20);
    check(nobs == ob0, "R5 no transitions while idle", nobs - ob0, 0);
    check(line_a_out == a0 && line_b_out == b0, "R5 levels held",
          {line_a_out, line_b_out}, {a0, b0});
  endtask

  task automatic t_loop(input logic [1:0] spd, input int n);
    int ob0, g0, be0, ge0, rb, w, k, bad;
    ob0 = nobs; g0 = ngot; be0 = both_err; ge0 = gap_err; rb = 0; w = wpb(spd);
    rx_en = 1'b0;
    sys_cycles(2);
    rx_speed = spd; rx_ready = 1'b1; exp_gap = fpb(spd); gap_on = 1'b1;
    sys_cycles(2);
    rx_en = 1'b1;
    sys_cycles(2);
    send_words(spd, n, rb);
    sys_cycles(30);
    check(both_err == be0, "R2 one line per bit", both_err - be0, 0);
    check(gap_err == ge0, "R3 bit spacing", gap_err - ge0, 0);
    check(nobs - ob0 == n * w, "R3 bit count", nobs - ob0, n * w);
    bad = 0; k = ob0;
    for (int i = 0; i < n; i++)
      for (int j = w - 1; j >= 0; j--) begin
        if (k < 4096 && obs[k] != txw[i][j]) bad++;
        k++;
      end
    check(bad == 0, "R4 MSB-first line bits", bad, 0);
    check(ngot - g0 == n, "R6 received word count", ngot - g0, n);
    for (int i = 0; i < n; i++)
      check(got[g0+i] == (txw[i] & msk(spd)), "R6 received word",
            got[g0+i], txw[i] & msk(spd));
    check(rb == 0, "R9 tx_ready during stream", rb, 0);
    check(rx_overflow == 1'b0, "R8 no overflow in flow", rx_overflow, 0);
    gap_on = 1'b0;
    rx_en = 1'b0;
    sys_cycles(2);
  endtask

  task automatic t_rx_disabled();
    int g0, rb;
    g0 = ngot; rb = 0;
    rx_en = 1'b0; rx_speed = 2'd2; rx_ready = 1'b1;
    txw[0] = 8'h11; txw[1] = 8'h22; txw[2] = 8'h33; txw[3] = 8'h44;
    sys_cycles(2);
    send_words(2'd2, 4, rb);
    sys_cycles(30);
    check(ngot == g0, "R6 nothing while rx_en low", ngot - g0, 0);
    check(rx_valid == 1'b0, "R6 rx_valid low while disabled", rx_valid, 0);
  endtask

  task automatic t_restart();
    int g0, rb;
    rb = 0;
    rx_en = 1'b0; rx_speed = 2'd2; rx_ready = 1'b1;
    sys_cycles(2);
    rx_en = 1'b1;
    sys_cycles(2);
    txw[0] = 8'h02;
    send_words(2'd0, 1, rb);
    sys_cycles(20);
    rx_en = 1'b0;
    sys_cycles(3);
    g0 = ngot;
    rx_en = 1'b1;
    sys_cycles(2);
    txw[0] = 8'hC6; txw[1] = 8'h39;
    send_words(2'd2, 2, rb);
    sys_cycles(30);
    check(ngot - g0 == 2, "R6 count after restart", ngot - g0, 2);
    check(got[g0] == 8'hC6, "R6 word aligned after restart", got[g0], 8'hC6);
    check(got[g0+1] == 8'h39, "R6 second word after restart", got[g0+1], 8'h39);
    rx_en = 1'b0;
    sys_cycles(2);
  endtask

  task automatic t_backpressure();
    int g0, rb;
    logic [7:0] w0;
    rb = 0;
    rx_en = 1'b0; rx_speed = 2'd2; rx_ready = 1'b0;
    txw[0] = 8'h5E; txw[1] = 8'hA1; txw[2] = 8'h07;
    sys_cycles(2);
    rx_en = 1'b1;
    sys_cycles(2);
    g0 = ngot;
    send_words(2'd2, 3, rb);
    sys_cycles(30);
    check(rx_valid == 1'b1, "R7 valid held under back-pressure", rx_valid, 1);
    check(rx_word == 8'h5E, "R7 oldest word presented", rx_word, 8'h5E);
    w0 = rx_word;
    sys_cycles(6);
    check(rx_valid == 1'b1 && rx_word == w0, "R7 word stable while not ready", rx_word, w0);
    check(ngot == g0, "R7 no transfer while not ready", ngot - g0, 0);
    rx_ready = 1'b1;
    sys_cycles(10);
    check(ngot - g0 == 3, "R7 all words delivered", ngot - g0, 3);
    for (int i = 0; i < 3; i++)
      check(got[g0+i] == txw[i], "R7 order kept", got[g0+i], txw[i]);
    check(rx_overflow == 1'b0, "R8 no overflow under light back-pressure", rx_overflow, 0);
    rx_en = 1'b0;
    sys_cycles(2);
  endtask

  task automatic t_overflow();
    int g0, rb;
    rb = 0;
    rx_en = 1'b0; rx_speed = 2'd2; rx_ready = 1'b0;
    txw[0] = 8'h10; txw[1] = 8'h21; txw[2] = 8'h32; txw[3] = 8'h43;
    txw[4] = 8'h54; txw[5] = 8'h65; txw[6] = 8'h76;
    sys_cycles(2);
    rx_en = 1'b1;
    sys_cycles(2);
    g0 = ngot;
    send_words(2'd2, 7, rb);
    sys_cycles(30);
    check(rx_overflow == 1'b1, "R8 overflow raised", rx_overflow, 1);
    rx_ready = 1'b1;
    sys_cycles(20);
    check(ngot - g0 == 4, "R8 four words retained", ngot - g0, 4);
    for (int i = 0; i < 4; i++)
      check(got[g0+i] == txw[i], "R8 oldest words kept", got[g0+i], txw[i]);
    check(rx_overflow == 1'b1, "R8 overflow sticky", rx_overflow, 1);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge bit_clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (10) @(negedge bit_clk);
    t_reset_pre();
    rst_n = 1'b1;
    t_reset();
    t_idle();
    txw[0] = 8'hA5; txw[1] = 8'h00; txw[2] = 8'hFF; txw[3] = 8'h3C;
    txw[4] = 8'h81; txw[5] = 8'h5A;
    t_loop(2'd2, 6);
    txw[0] = 8'hF3; txw[1] = 8'h0C; txw[2] = 8'h9F; txw[3] = 8'h60; txw[4] = 8'hA5;
    t_loop(2'd1, 5);
    txw[0] = 8'hFE; txw[1] = 8'h01; txw[2] = 8'h03; txw[3] = 8'h00; txw[4] = 8'h42;
    t_loop(2'd0, 5);
    txw[0] = 8'h96; txw[1] = 8'hFF; txw[2] = 8'h00; txw[3] = 8'h7E;
    t_loop(2'd3, 4);
    t_rx_disabled();
    t_restart();
    t_backpressure();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic t_reset_pre();
    check(line_a_out == 1'b0 && line_b_out == 1'b0, "R1 lines in reset",
          {line_a_out, line_b_out}, 0);
    check(rx_valid == 1'b0 && rx_overflow == 1'b0, "R1 rx outputs in reset",
          {rx_valid, rx_overflow}, 0);
  endtask
endmodule